// File: doc/BRIEF.md
# Global Counter With Compare Timer

This block keeps a free-running shared tick counter. Software reads and writes it as two 32-bit words over a single-cycle register port. A configuration word holds a stop control. The same word reports, read-only, how wide the counter is built and how many interrupt sources and cores the surrounding controller carries. When software reads the low word, the block captures the upper half of the counter. A later read of the high word then returns that captured value, so the two words form one consistent count.

A compare register sits in a separate local register space. It is as wide as the counter and is also written as two words. On the clock edge where the counter equals the compare value, a sticky compare-pending flag is set. Any write to either compare word clears the flag. A mask bit has separate set and clear write locations. The single interrupt output is the pending flag gated by this mask. The port has `bus_local` to pick the shared (0) or local (1) space, and `bus_word`, a word index equal to the byte offset divided by four. Read data is combinational in the same cycle as the request.

Top module: `gcount_cmp_timer`

## Requirements
- R1: Reset state. The counter is zero, the stop bit is clear, and the compare value is all ones in its `CNT_W` bits. The pending flag, the mask and `irq` are all zero.
- R2: The counter advances by one on every clock while the stop bit is clear. After 2^`CNT_W`-1 it wraps to zero.
- R3: The stop bit is shared offset 0x00 bit 28. It reads back as written. While it is 1, the counter holds its value.
- R4: The other bits of shared offset 0x00 are read-only and ignore writes. Bits 27:24 read `CNT_W`/4-8. Bits 15:8 read `NUM_IRQ`. Bits 7:0 read `NUM_CORE`. All remaining bits read zero.
- R5: A write to shared offset 0x10 loads counter bits 31:0. A write to shared offset 0x14 loads the counter bits above 31. Bits beyond `CNT_W` are dropped. The written value is present from the next cycle, in place of that cycle's increment. A read of 0x10 returns the live counter bits 31:0.
- R6: A read of shared offset 0x10 captures counter bits 63:32 (zero above `CNT_W`). A read of 0x14 returns the captured value, not the live one. The captured value is zero after reset.
- R7: The compare value is written and read back at local offset 0xA0 (bits 31:0) and local offset 0xA4 (upper bits). Bits beyond `CNT_W` read zero.
- R8: Compare-pending reads at local offset 0x04 bit 1. It is set on a clock edge where the counter equals the compare value, and it then stays set. A write to local offset 0xA0 or 0xA4 clears it, and this clear wins over a match on the same edge.
- R9: Writing 1 to bit 1 at local offset 0x10 sets the mask. Writing 1 to bit 1 at local offset 0x0C clears it. Other data bits in these writes have no effect. The mask reads at local offset 0x08 bit 1.
- R10: `irq` is high exactly when both the pending flag and the mask are set.
- R11: Offsets not listed above read zero, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_local | input | 1 | 0 selects the shared space, 1 selects the local space |
| bus_word | input | 6 | Word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_re | input | 1 | Read strobe; a low-word read captures the upper counter half |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the selected word |
| irq | output | 1 | Masked compare interrupt |

## Verification
The bench builds the block with `CNT_W`=40, `NUM_IRQ`=24 and `NUM_CORE`=2. With a 40-bit counter, the upper word holds only 8 live bits. This makes the truncation of high-word writes, the zero bits above the width and the width code of 2 all visible. It also lets a directed case write the counter close to its top value and watch it wrap through zero within a few cycles. Compare writes are aimed a few ticks ahead of the running count, so random traffic reaches real matches, sticky pending, masking and write-clear races.

// File: rtl/gcount_cmp_timer.sv
module gcount_cmp_timer #(
  parameter int CNT_W    = 64,
  parameter int NUM_IRQ  = 64,
  parameter int NUM_CORE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_local,
  input  logic [5:0]  bus_word,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);

  localparam logic [3:0] WIDTH_CODE = 4'(CNT_W / 4 - 8);
  localparam logic [7:0] IRQ_CNT    = 8'(NUM_IRQ);
  localparam logic [7:0] CORE_CNT   = 8'(NUM_CORE);

  localparam logic [5:0] W_CFG   = 6'h00;
  localparam logic [5:0] W_CLO   = 6'h04;
  localparam logic [5:0] W_CHI   = 6'h05;
  localparam logic [5:0] W_PEND  = 6'h01;
  localparam logic [5:0] W_MASK  = 6'h02;
  localparam logic [5:0] W_RMASK = 6'h03;
  localparam logic [5:0] W_SMASK = 6'h04;
  localparam logic [5:0] W_PLO   = 6'h28;
  localparam logic [5:0] W_PHI   = 6'h29;

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [31:0]      shadow_q;
  logic             stop_q, pend_q, mask_q;
  logic [63:0]      cnt_x, cmp_x;

  assign cnt_x = 64'(cnt_q);
  assign cmp_x = 64'(cmp_q);

  wire sh_wr  = bus_we & ~bus_local;
  wire lc_wr  = bus_we &  bus_local;
  wire wr_cfg = sh_wr & (bus_word == W_CFG);
  wire wr_clo = sh_wr & (bus_word == W_CLO);
  wire wr_chi = sh_wr & (bus_word == W_CHI);
  wire rd_clo = bus_re & ~bus_local & (bus_word == W_CLO);
  wire wr_plo = lc_wr & (bus_word == W_PLO);
  wire wr_phi = lc_wr & (bus_word == W_PHI);
  wire wr_rm  = lc_wr & (bus_word == W_RMASK) & bus_wdata[1];
  wire wr_sm  = lc_wr & (bus_word == W_SMASK) & bus_wdata[1];
  wire hit    = (cnt_q == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cmp_q    <= '1;
      shadow_q <= '0;
      stop_q   <= 1'b0;
      pend_q   <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      if (wr_clo)      cnt_q <= CNT_W'({cnt_x[63:32], bus_wdata});
      else if (wr_chi) cnt_q <= CNT_W'({bus_wdata, cnt_x[31:0]});
      else if (!stop_q) cnt_q <= cnt_q + 1'b1;

      if (wr_cfg) stop_q <= bus_wdata[28];
      if (rd_clo) shadow_q <= cnt_x[63:32];

      if (wr_plo)      cmp_q <= CNT_W'({cmp_x[63:32], bus_wdata});
      else if (wr_phi) cmp_q <= CNT_W'({bus_wdata, cmp_x[31:0]});

      if (wr_plo | wr_phi) pend_q <= 1'b0;
      else if (hit)        pend_q <= 1'b1;

      if (wr_rm)      mask_q <= 1'b0;
      else if (wr_sm) mask_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_local) begin
      case (bus_word)
        W_CFG:   bus_rdata = {3'b000, stop_q, WIDTH_CODE, 8'h00, IRQ_CNT, CORE_CNT};
        W_CLO:   bus_rdata = cnt_x[31:0];
        W_CHI:   bus_rdata = shadow_q;
        default: bus_rdata = '0;
      endcase
    end else begin
      case (bus_word)
        W_PEND:  bus_rdata = {30'b0, pend_q, 1'b0};
        W_MASK:  bus_rdata = {30'b0, mask_q, 1'b0};
        W_PLO:   bus_rdata = cmp_x[31:0];
        W_PHI:   bus_rdata = cmp_x[63:32];
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = pend_q & mask_q;

endmodule

// File: rtl/gcount_cmp_timer_chk.sv
module gcount_cmp_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_local,
  input logic [5:0]       bus_word,
  input logic             bus_we,
  input logic             wbit1,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             stop_q,
  input logic             pend_q,
  input logic             irq
);

  wire cnt_wr = bus_we & ~bus_local & ((bus_word == 6'h04) | (bus_word == 6'h05));
  wire cmp_wr = bus_we &  bus_local & ((bus_word == 6'h28) | (bus_word == 6'h29));
  wire rm_wr  = bus_we &  bus_local & (bus_word == 6'h03) & wbit1;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_q && !cnt_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !cnt_wr) |=> $stable(cnt_q));

  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !pend_q);

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == cmp_q) && !cmp_wr) |=> pend_q);

  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm_wr |=> !irq);

endmodule

bind gcount_cmp_timer gcount_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_local(bus_local), .bus_word(bus_word),
  .bus_we(bus_we), .wbit1(bus_wdata[1]), .cnt_q(cnt_q), .cmp_q(cmp_q),
  .stop_q(stop_q), .pend_q(pend_q), .irq(irq)
);

// File: tb/gcount_cmp_timer_test.sv
`timescale 1ns/1ps
module gcount_cmp_timer_test;
  localparam int CNT_W = 40, NUM_IRQ = 24, NUM_CORE = 2;

  logic clk = 0, rst_n = 0;
  logic bus_local = 0, bus_we = 0, bus_re = 0, irq;
  logic [5:0] bus_word = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  int nvec = 0, nerr = 0;

  always #4 clk = ~clk;

  gcount_cmp_timer #(.CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_local(bus_local), .bus_word(bus_word),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  logic [CNT_W-1:0] m_cnt, m_cmp;
  logic [31:0] m_shadow;
  logic m_stop, m_pend, m_mask;
  logic [63:0] m_cx, m_px;
  assign m_cx = 64'(m_cnt);
  assign m_px = 64'(m_cmp);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp <= '1; m_shadow <= '0;
      m_stop <= 0; m_pend <= 0; m_mask <= 0;
    end else begin
      if (bus_we && !bus_local && bus_word == 6'h04) m_cnt <= CNT_W'({m_cx[63:32], bus_wdata});
      else if (bus_we && !bus_local && bus_word == 6'h05) m_cnt <= CNT_W'({bus_wdata, m_cx[31:0]});
      else if (!m_stop) m_cnt <= m_cnt + 1'b1;
      if (bus_we && !bus_local && bus_word == 6'h00) m_stop <= bus_wdata[28];
      if (bus_re && !bus_local && bus_word == 6'h04) m_shadow <= m_cx[63:32];
      if (bus_we && bus_local && bus_word == 6'h28) m_cmp <= CNT_W'({m_px[63:32], bus_wdata});
      if (bus_we && bus_local && bus_word == 6'h29) m_cmp <= CNT_W'({bus_wdata, m_px[31:0]});
      if (bus_we && bus_local && (bus_word == 6'h28 || bus_word == 6'h29)) m_pend <= 0;
      else if (m_cnt == m_cmp) m_pend <= 1;
      if (bus_we && bus_local && bus_word == 6'h03 && bus_wdata[1]) m_mask <= 0;
      else if (bus_we && bus_local && bus_word == 6'h04 && bus_wdata[1]) m_mask <= 1;
    end
  end

  function automatic logic [31:0] exp_rd(input logic loc, input logic [5:0] w);
    if (!loc) begin
      if (w == 6'h00) return {3'b0, m_stop, 4'(CNT_W/4-8), 8'h00, 8'(NUM_IRQ), 8'(NUM_CORE)};
      if (w == 6'h04) return m_cx[31:0];
      if (w == 6'h05) return m_shadow;
    end else begin
      if (w == 6'h01) return {30'b0, m_pend, 1'b0};
      if (w == 6'h02) return {30'b0, m_mask, 1'b0};
      if (w == 6'h28) return m_px[31:0];
      if (w == 6'h29) return m_px[63:32];
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic loc, input logic [5:0] w);
    if (!loc) begin
      if (w == 6'h00) return "R3/R4";
      if (w == 6'h04) return "R2/R5";
      if (w == 6'h05) return "R6";
    end else begin
      if (w == 6'h01) return "R8";
      if (w == 6'h02) return "R9";
      if (w == 6'h28 || w == 6'h29) return "R7";
    end
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic loc, input logic [5:0] w, input logic we,
                       input logic re, input logic [31:0] wd, input string tag);
    @(negedge clk);
    bus_local = loc; bus_word = w; bus_we = we; bus_re = re; bus_wdata = wd;
    #1;
    if (re) check(tag == "" ? tag_of(loc, w) : tag, bus_rdata, exp_rd(loc, w));
    check("R10", {31'b0, irq}, {31'b0, m_pend & m_mask});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_op(0, 6'h3f, 0, 0, 0, "");
  endtask

  task automatic rst_read(input logic loc, input logic [5:0] w, input logic [31:0] exp);
    @(negedge clk);
    bus_local = loc; bus_word = w; bus_we = 0; bus_re = 1;
    #1;
    check("R1", bus_rdata, exp);
    check("R1", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1357_2468));
    repeat (2) @(negedge clk);
    rst_read(0, 6'h04, 32'h0);
    rst_read(0, 6'h05, 32'h0);
    rst_read(0, 6'h00, {4'b0, 4'd2, 8'h00, 8'd24, 8'd2});
    rst_read(1, 6'h28, 32'hFFFF_FFFF);
    rst_read(1, 6'h29, 32'h0000_00FF);
    rst_read(1, 6'h01, 32'h0);
    rst_read(1, 6'h02, 32'h0);
    @(negedge clk); bus_re = 0; rst_n = 1;

    idle(3);
    do_op(0, 6'h04, 0, 1, 0, "R2");
    do_op(0, 6'h04, 0, 1, 0, "R2");

    // R3 / R4: stop with all-ones write, fields unchanged
    do_op(0, 6'h00, 1, 0, 32'hFFFF_FFFF, "");
    do_op(0, 6'h04, 0, 1, 0, "R3");
    v = bus_rdata;
    idle(5);
    do_op(0, 6'h04, 0, 1, 0, "R3");
    check("R3", bus_rdata, v);
    do_op(0, 6'h00, 0, 1, 0, "R4");
    check("R4", bus_rdata, 32'h1200_1802);
    do_op(0, 6'h00, 1, 0, 32'h0, "");

    // R5 truncation and R2 wrap
    do_op(0, 6'h05, 1, 0, 32'hFFFF_FFFF, "");
    do_op(0, 6'h04, 1, 0, 32'hFFFF_FFFD, "");
    do_op(0, 6'h04, 0, 1, 0, "R2");
    do_op(0, 6'h05, 0, 1, 0, "R5");
    check("R5", bus_rdata, 32'h0000_00FF);
    do_op(0, 6'h04, 0, 1, 0, "R2");
    do_op(0, 6'h04, 0, 1, 0, "R2");
    do_op(0, 6'h05, 0, 1, 0, "R2");
    check("R2", bus_rdata, 32'h0);

    // R6 captured high word is stale, not live
    do_op(0, 6'h05, 1, 0, 32'h0000_0007, "");
    do_op(0, 6'h04, 1, 0, 32'hFFFF_FFFE, "");
    do_op(0, 6'h04, 0, 1, 0, "R6");
    idle(4);
    do_op(0, 6'h05, 0, 1, 0, "R6");
    check("R6", bus_rdata, 32'h0000_0007);

    // R8/R9/R10 compare hit
    do_op(0, 6'h04, 1, 0, 32'h0000_1000, "");
    do_op(1, 6'h29, 1, 0, m_cx[63:32], "");
    do_op(1, 6'h28, 1, 0, m_cx[31:0] + 12, "");
    do_op(1, 6'h04, 1, 0, 32'hFFFF_FFFD, "");
    do_op(1, 6'h02, 0, 1, 0, "R9");
    check("R9", bus_rdata, 32'h0);
    do_op(1, 6'h04, 1, 0, 32'h0000_0002, "");
    idle(14);
    do_op(1, 6'h01, 0, 1, 0, "R8");
    check("R8", bus_rdata, 32'h2);
    check("R10", {31'b0, irq}, 32'h1);
    do_op(1, 6'h03, 1, 0, 32'hFFFF_FFFD, "");
    do_op(1, 6'h02, 0, 1, 0, "R9");
    check("R9", bus_rdata, 32'h2);
    do_op(1, 6'h28, 1, 0, 32'h0, "");
    do_op(1, 6'h01, 0, 1, 0, "R8");
    check("R8", bus_rdata, 32'h0);
    do_op(1, 6'h03, 1, 0, 32'h2, "");
    check("R9", {31'b0, irq}, 32'h0);
    do_op(1, 6'h28, 0, 1, 0, "R7");
    check("R7", bus_rdata, 32'h0);
    do_op(1, 6'h29, 0, 1, 0, "R7");

    // R11 unmapped
    do_op(0, 6'h10, 1, 0, 32'hFFFF_FFFF, "");
    do_op(1, 6'h3f, 1, 0, 32'hFFFF_FFFF, "");
    do_op(0, 6'h10, 0, 1, 0, "R11");
    do_op(1, 6'h3f, 0, 1, 0, "R11");

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [5:0] rw;
      r = $urandom % 16;
      case (r)
        0, 1, 2, 3: begin
          case ($urandom % 9)
            0: rw = 6'h00; 1: rw = 6'h04; 2: rw = 6'h05; 3: rw = 6'h01;
            4: rw = 6'h02; 5: rw = 6'h28; 6: rw = 6'h29; 7: rw = 6'h03;
            default: rw = 6'($urandom);
          endcase
          do_op(r[0], rw, 0, 1, 0, "");
        end
        4: do_op(0, 6'h00, 1, 0, ($urandom % 5 == 0) ? 32'h1000_0000 : ($urandom & 32'hEFFF_FFFF), "");
        5: do_op(0, 6'h04, 1, 0, ($urandom % 2) ? $urandom : 32'hFFFF_FFF0 + ($urandom % 16), "");
        6: do_op(0, 6'h05, 1, 0, $urandom, "");
        7: do_op(1, 6'h28, 1, 0, m_cx[31:0] + ($urandom % 24), "");
        8: do_op(1, 6'h29, 1, 0, m_cx[63:32], "");
        9: do_op(1, 6'h04, 1, 0, $urandom, "");
        10: do_op(1, 6'h03, 1, 0, ($urandom % 3 == 0) ? 32'h2 : 32'h0, "");
        11: do_op(r[0], 6'($urandom), 1, 0, $urandom, "");
        12: begin do_op(0, 6'h04, 0, 1, 0, ""); do_op(0, 6'h05, 0, 1, 0, ""); end
        default: idle(1);
      endcase
    end
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule